// File: doc/BRIEF.md
# Dual-Slope Converter Phase Sequencer

This block is the digital controller for an external dual-slope integrating converter. It runs from a system timebase and steps the analog front end through four phases on a two-bit phase code: auto-zero, integrate, de-integrate and integrator-zero, then back to auto-zero. The auto-zero and integrate phases last a number of clocks set by an 8-bit preset. De-integration ends when the comparator reports a zero crossing. Integrator-zero ends when the comparator is high again.

The preset does not hold a count directly. It is loaded as the high byte of a 16-bit up-counter whose low byte starts at zero, and a phase ends when the counter reaches all ones. Both timed phases therefore last 65536 - 256*preset clocks. De-integration reuses the same counter from zero. When it ends, the count, a polarity bit and an overrange bit are captured in one result word, and a single-cycle ready pulse marks the capture. An active-low chip enable and an active-low load strobe both restart the sequence in auto-zero. Only the load strobe stores a new preset.

Top module: `dsadc_seq`

## Requirements
- R1: While reset is asserted and on the first sample after it, the phase code is 00 (integrator-zero), the ready output is 0 and the result is 0.
- R2: In integrator-zero (code 00) the block stays in that phase while the synchronized comparator is low. It moves to auto-zero on the clock after the synchronized comparator is seen high.
- R3: A low level on ce_n or on load_n at a clock edge puts the phase code at auto-zero (01) after that edge, from any phase, and it aborts a de-integration without a ready pulse.
- R4: load_n low stores the preset. Auto-zero and integrate each last 65536 - 256*preset clocks, counted from the phase entry. A preset that changes while load_n is high has no effect.
- R5: Phase codes are auto-zero = 01, integrate = 10, de-integrate = 11 and integrator-zero = 00. Without a forced restart the order is 01, 10, 11, 00, 01.
- R6: De-integrate (11) starts on the clock directly after the last integrate clock, with its counter at zero.
- R7: De-integration ends on the clock after the synchronized comparator changes level. The captured count in result[15:0] equals the number of de-integrate clocks before the change was seen. A comparator toggle driven w clocks after de-integration begins gives a count of w+2.
- R8: If the de-integration counter passes 65535, result[17] (overrange) is 1 and result[15:0] holds the wrapped count.
- R9: result[16] (polarity) is the synchronized comparator level on the last clock of integrate.
- R10: rdy is high for exactly one clock per finished de-integration. The result changes only together with rdy.
- R11: The comparator passes through two flip-flops before use. A rise driven just before edge k becomes a phase change at edge k+2 at the earliest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System timebase |
| rst_n | input | 1 | Active-low power-on reset |
| cmp_in | input | 1 | Comparator output from the analog front end (asynchronous) |
| ce_n | input | 1 | Active-low enable; low forces auto-zero |
| load_n | input | 1 | Active-low preset strobe; low stores preset and forces auto-zero |
| preset | input | 8 | High byte of the auto-zero/integrate timing counter |
| phase | output | 2 | Current phase code (00 izero, 01 azero, 10 integ, 11 deint) |
| rdy | output | 1 | One-clock pulse when a new result is captured |
| result | output | 18 | {overrange, polarity, 16-bit de-integration count} |

## Verification
The hardest situation to reach is overrange. The comparator has to stay still for more than 65536 de-integrate clocks, and only then change, so that the wrapped count and the flag both appear. The stimulus uses the shortest timed phases (preset 255 and 254) to reach de-integration quickly. It then holds the comparator for a fixed number of clocks past a full wrap and predicts the result as that number plus the two synchronizer stages, minus 65536. A forced restart in the middle of de-integration is placed the same way, by waiting on the observed phase code before pulsing the load strobe.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [1:0] {
    PH_IZ   = 2'b00,
    PH_AZ   = 2'b01,
    PH_INT  = 2'b10,
    PH_DINT = 2'b11
  } phase_e;

  // Successor of a phase in an uninterrupted conversion.
  function automatic phase_e phase_succ(input phase_e p);
    case (p)
      PH_AZ:   return PH_INT;
      PH_INT:  return PH_DINT;
      PH_DINT: return PH_IZ;
      default: return PH_AZ;
    endcase
  endfunction

endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic lvl_prev
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], d};
  end

  assign lvl      = sh[STAGES-1];
  assign lvl_prev = sh[STAGES];

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_prev == $past(lvl)) else $error("sync prev mismatch"); // R11
endmodule

// File: rtl/dsadc_timer.sv
module dsadc_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             inc_en,
  output logic [CNT_W-1:0] cnt,
  output logic             at_full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (load_en) cnt <= load_val;
    else if (inc_en)  cnt <= cnt + 1'b1;
  end

  assign at_full = &cnt;

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !load_en) |=> (cnt == $past(cnt) + 1'b1)) else $error("timer step"); // R4
  AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cnt == $past(load_val))) else $error("timer load"); // R4
endmodule

// File: rtl/dsadc_fsm.sv
module dsadc_fsm
  import dsadc_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int RES_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             force_az,
  input  logic             cmp_lvl,
  input  logic             cmp_edge,
  input  logic [CNT_W-1:0] base,
  input  logic [CNT_W-1:0] cnt,
  input  logic             at_full,
  output phase_e           phase,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             tmr_inc,
  output logic             rdy,
  output logic [RES_W-1:0] result
);
  phase_e phase_nxt;
  logic   pol, ovr;
  // named internal events
  logic   int_done, dint_done, ovr_set;

  always_comb begin
    phase_nxt = phase;
    tmr_load  = 1'b0;
    tmr_val   = base;
    tmr_inc   = 1'b0;
    if (force_az) begin
      phase_nxt = PH_AZ;
      tmr_load  = 1'b1;
    end else begin
      case (phase)
        PH_IZ: if (cmp_lvl) begin
          phase_nxt = PH_AZ;
          tmr_load  = 1'b1;
        end
        PH_AZ: if (at_full) begin
          phase_nxt = PH_INT;
          tmr_load  = 1'b1;
        end else tmr_inc = 1'b1;
        PH_INT: if (at_full) begin
          phase_nxt = PH_DINT;
          tmr_load  = 1'b1;
          tmr_val   = '0;
        end else tmr_inc = 1'b1;
        default: if (cmp_edge) phase_nxt = PH_IZ;
                 else          tmr_inc   = 1'b1;
      endcase
    end
  end

  assign int_done  = !force_az && (phase == PH_INT) && at_full;
  assign dint_done = !force_az && (phase == PH_DINT) && cmp_edge;
  assign ovr_set   = !force_az && (phase == PH_DINT) && !cmp_edge && at_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IZ;
      pol    <= 1'b0;
      ovr    <= 1'b0;
      rdy    <= 1'b0;
      result <= '0;
    end else begin
      phase <= phase_nxt;
      rdy   <= dint_done;
      if (int_done) begin
        pol <= cmp_lvl;
        ovr <= 1'b0;
      end else if (ovr_set) begin
        ovr <= 1'b1;
      end
      if (dint_done) result <= {ovr, pol, cnt};
    end
  end

  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase) && !$past(force_az)) |-> (phase == phase_succ($past(phase))))
    else $error("phase order"); // R5
  AST_FORCE_AZ: assert property (@(posedge clk) disable iff (!rst_n)
    force_az |=> (phase == PH_AZ)) else $error("force"); // R3
  AST_IZ_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IZ && !cmp_lvl && !force_az) |=> (phase == PH_IZ)) else $error("iz wait"); // R2
  AST_DINT_START: assert property (@(posedge clk) disable iff (!rst_n)
    int_done |=> (phase == PH_DINT && cnt == '0)) else $error("dint start"); // R6
  AST_RDY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> !rdy) else $error("rdy width"); // R10
  AST_RDY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> ($past(phase) == PH_DINT && $past(cmp_edge) && phase == PH_IZ)) else $error("rdy source"); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy |-> $stable(result)) else $error("result hold"); // R10
  AST_OVR_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |=> ovr) else $error("overrange"); // R8
  AST_POL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    int_done |=> (pol == $past(cmp_lvl))) else $error("polarity"); // R9
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRESET_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmp_in,
  input  logic                ce_n,
  input  logic                load_n,
  input  logic [PRESET_W-1:0] preset,
  output logic [1:0]          phase,
  output logic                rdy,
  output logic [CNT_W+1:0]    result
);
  localparam int LOW_W = CNT_W - PRESET_W;

  // preset forms the high part of the start value, low part cleared
  function automatic logic [CNT_W-1:0] start_count(input logic [PRESET_W-1:0] p);
    return {p, {LOW_W{1'b0}}};
  endfunction

  logic [PRESET_W-1:0] load_reg, eff_preset;
  logic                force_az, cmp_lvl, cmp_prev, cmp_edge;
  logic [CNT_W-1:0]    base, cnt, tmr_val;
  logic                at_full, tmr_load, tmr_inc;
  phase_e              fsm_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       load_reg <= '0;
    else if (!load_n) load_reg <= preset;
  end

  assign force_az   = !ce_n || !load_n;
  assign eff_preset = load_n ? load_reg : preset;
  assign base       = start_count(eff_preset);
  assign cmp_edge   = cmp_lvl ^ cmp_prev;

  dsadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_in), .lvl(cmp_lvl), .lvl_prev(cmp_prev)
  );

  dsadc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_en(tmr_load), .load_val(tmr_val),
    .inc_en(tmr_inc), .cnt(cnt), .at_full(at_full)
  );

  dsadc_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .force_az(force_az), .cmp_lvl(cmp_lvl),
    .cmp_edge(cmp_edge), .base(base), .cnt(cnt), .at_full(at_full),
    .phase(fsm_phase), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .tmr_inc(tmr_inc), .rdy(rdy), .result(result)
  );

  assign phase = fsm_phase;

  AST_PRESET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> $stable(load_reg)) else $error("preset hold"); // R4
endmodule

// File: tb/dsadc_seq_bench.sv
module dsadc_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_in = 1'b0;
  logic        ce_n = 1'b1;
  logic        load_n = 1'b1;
  logic [7:0]  preset = 8'd0;
  logic [1:0]  phase_w;
  logic        rdy_w;
  logic [17:0] result_w;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk; // 50 MHz

  dsadc_seq u_dsadc_seq (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .ce_n(ce_n), .load_n(load_n),
    .preset(preset), .phase(phase_w), .rdy(rdy_w), .result(result_w)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_phase = 0, m_cnt = 0, m_pol = 0, m_ovr = 0, m_res = 0, m_rdy = 0, m_load = 0;
  int hist[$] = '{0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_pol = 0; m_ovr = 0; m_res = 0; m_rdy = 0; m_load = 0;
      hist = '{0, 0, 0};
    end else begin
      int  cur_load, lvl;
      bit  frc, edg;
      frc      = !ce_n || !load_n;
      cur_load = !load_n ? int'(preset) : m_load;
      lvl      = hist[1];
      edg      = hist[1] != hist[2];
      m_rdy    = 0;
      if (frc) begin
        m_phase = 1; m_cnt = cur_load * 256;
      end else begin
        case (m_phase)
          0: if (lvl != 0) begin m_phase = 1; m_cnt = cur_load * 256; end
          1: if (m_cnt == 65535) begin m_phase = 2; m_cnt = cur_load * 256; end
             else m_cnt++;
          2: if (m_cnt == 65535) begin m_phase = 3; m_pol = lvl; m_ovr = 0; m_cnt = 0; end
             else m_cnt++;
          default:
             if (edg) begin
               m_phase = 0; m_rdy = 1;
               m_res = m_ovr * 131072 + m_pol * 65536 + m_cnt;
             end else if (m_cnt == 65535) begin m_ovr = 1; m_cnt = 0; end
             else m_cnt++;
        endcase
      end
      m_load = cur_load;
      hist.push_front(int'(cmp_in));
      void'(hist.pop_back());
    end
    #5;
    if (rst_n) begin
      chk(phase_w == m_phase[1:0], "R5 model phase", 32'(phase_w), m_phase);
      chk(rdy_w == m_rdy[0], "R10 model rdy", 32'(rdy_w), m_rdy);
      chk(result_w == m_res[17:0], "R7 model result", 32'(result_w), m_res);
    end
  end

  // ---------------- helpers ----------------
  task automatic sample();
    @(posedge clk); #5;
  endtask

  task automatic count_phase(input logic [1:0] ph, output int n, output logic [1:0] nxt);
    bit done = 0;
    n = 0; nxt = ph;
    while (!done) begin
      sample();
      if (phase_w !== ph) begin nxt = phase_w; done = 1; end
      else begin n++; if (n > 70000) done = 1; end
    end
  endtask

  // toggles comparator w clocks into de-integration (called at first DINT sample)
  task automatic dint_toggle(input int w, input logic lvl_new, input int exp_word, input string req);
    int k = 0;
    repeat (w + 1) @(negedge clk);
    cmp_in = lvl_new;
    do begin sample(); k++; end while (!rdy_w && k < 100);
    chk(rdy_w == 1'b1, {req, " rdy seen"}, 32'(rdy_w), 1);
    chk(result_w == exp_word[17:0], req, 32'(result_w), exp_word);
    chk(phase_w == 2'b00, "R5 izero after deint", 32'(phase_w), 0);
    sample();
    chk(rdy_w == 1'b0, "R10 rdy one cycle", 32'(rdy_w), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int n;
    logic [1:0] nx;
    repeat (4) @(negedge clk);
    chk(phase_w == 2'b00 && rdy_w == 1'b0, "R1 phase/rdy in reset", {phase_w, rdy_w}, 0);
    rst_n = 1'b1;
    sample();
    chk(phase_w == 2'b00, "R1 phase after reset", 32'(phase_w), 0);
    chk(rdy_w == 1'b0, "R1 rdy after reset", 32'(rdy_w), 0);
    chk(result_w == 18'd0, "R1 result after reset", 32'(result_w), 0);
    repeat (10) sample();
    chk(phase_w == 2'b00, "R2 izero waits for comparator", 32'(phase_w), 0);

    // load preset 255 -> 256-clock phases
    @(negedge clk); load_n = 1'b0; preset = 8'd255;
    sample();
    chk(phase_w == 2'b01, "R3 load strobe forces azero", 32'(phase_w), 1);
    @(negedge clk); load_n = 1'b1; preset = 8'd0;
    count_phase(2'b01, n, nx);
    chk(n + 1 == 256, "R4 azero length p=255", n + 1, 256);
    chk(nx == 2'b10, "R5 azero then integrate", 32'(nx), 2);
    count_phase(2'b10, n, nx);
    chk(n + 1 == 256, "R4 integrate length p=255", n + 1, 256);
    chk(nx == 2'b11, "R6 deint right after integrate", 32'(nx), 3);
    dint_toggle(12, 1'b1, 14, "R7 count w+2, R9 polarity 0");
    chk(phase_w == 2'b01, "R2 izero to azero with comparator high", 32'(phase_w), 1);

    // conversion 2: preset change without strobe ignored, polarity 1
    count_phase(2'b01, n, nx);
    chk(n + 1 == 256, "R4 preset change without strobe ignored", n + 1, 256);
    count_phase(2'b10, n, nx);
    chk(nx == 2'b11, "R6 deint follows integrate", 32'(nx), 3);
    dint_toggle(37, 1'b0, 65536 + 39, "R9 polarity 1, R7 count");
    repeat (5) sample();
    chk(phase_w == 2'b00, "R2 izero holds while comparator low", 32'(phase_w), 0);
    @(negedge clk); cmp_in = 1'b1;
    sample();
    chk(phase_w == 2'b00, "R11 sync stage 1", 32'(phase_w), 0);
    sample();
    chk(phase_w == 2'b00, "R11 sync stage 2", 32'(phase_w), 0);
    sample();
    chk(phase_w == 2'b01, "R11 azero after two stages", 32'(phase_w), 1);

    // forced restart during integrate with ce_n
    count_phase(2'b01, n, nx);
    @(negedge clk); ce_n = 1'b0;
    sample();
    chk(phase_w == 2'b01, "R3 ce_n forces azero from integrate", 32'(phase_w), 1);
    @(negedge clk); ce_n = 1'b1;
    count_phase(2'b01, n, nx);
    chk(n + 1 == 256, "R4 azero restarts full after force", n + 1, 256);
    count_phase(2'b10, n, nx);
    chk(nx == 2'b11, "R6 deint entered", 32'(nx), 3);

    // abort de-integration with load strobe, new preset 254
    @(negedge clk); load_n = 1'b0; preset = 8'd254;
    sample();
    chk(phase_w == 2'b01, "R3 load strobe aborts deint", 32'(phase_w), 1);
    chk(rdy_w == 1'b0, "R3 no rdy on abort", 32'(rdy_w), 0);
    @(negedge clk); load_n = 1'b1; preset = 8'd7;
    count_phase(2'b01, n, nx);
    chk(n + 1 == 512, "R4 azero length p=254", n + 1, 512);
    count_phase(2'b10, n, nx);
    chk(n + 1 == 512, "R4 integrate length p=254", n + 1, 512);

    // overrange: hold comparator past full count
    dint_toggle(65556, 1'b0, 131072 + 65536 + 22, "R8 overrange wrapped count");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule